// File: doc/BRIEF.md
# Performance monitor counter unit

This block gives a processor core a small set of performance counters. It holds three counters: one counts core clock cycles, and two count hardware event lines. A single control word sets how they behave. Software reaches the control word and the counters through a plain register port with a 2-bit index, a write strobe, write data and combinational read data. A write lands on the rising clock edge, and reads show the current register contents.

The cycle counter advances on every enabled cycle. It can instead advance once every 64 enabled cycles when the prescaler bit is set. Each event counter picks one line of a 16-bit event bus through an 8-bit selector, and adds one on every enabled cycle in which that line is high. When a counter rolls over from all ones to zero, it sets a sticky flag and keeps counting. A flag whose interrupt enable is set drives the level-sensitive interrupt output. The control word also carries two self-clearing command bits that zero the counters. The register port has no handshake: every access completes in one cycle.

Top module: `perf_mon_unit`

## Requirements
- R1: Register index 0 is the control word, 1 the cycle counter, 2 event counter 0, 3 event counter 1. After reset every register reads 0 and irq is 0. In the control word, bit 0 is the global enable, bit 3 is the divide-by-64 select, bits 6:4 are the interrupt enables, bits 10:8 are the overflow flags, bits 19:12 select the event for counter 0 and bits 27:20 select the event for counter 1. All other bits, including the command bits 1 and 2, read as 0.
- R2: While enable (bit 0) is 0, no counter changes except through a software write or a clear command. A write to the control word takes effect after its edge, so the edge of that write still uses the old enable.
- R3: Writing 1 to control bit 1 zeroes both event counters, and writing 1 to bit 2 zeroes the cycle counter and its prescaler. Either clear wins over an increment on the same edge.
- R4: With divide (bit 3) clear, the cycle counter adds one on every enabled edge. With it set, the counter adds one on every 64th enabled edge after the prescaler was last cleared.
- R5: Event counter n adds one on each enabled edge on which evt_in[selector n] is high. A selector value of 16 or more counts nothing.
- R6: A counter that steps from 0xFFFFFFFF wraps to 0, keeps counting, and sets its overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter.
- R7: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. An overflow on the same edge as the clearing write leaves the flag set.
- R8: irq is high when any flag is set together with its enable. Enable bit 4 pairs with flag bit 8, bit 5 with bit 9, and bit 6 with bit 10.
- R9: A software write to a counter register loads the written value, and takes priority over that counter's increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register index for reads and writes |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Contents of the indexed register |
| evt_in | input | 16 | Hardware event lines, sampled each cycle |
| irq | output | 1 | Level interrupt, OR of enabled overflow flags |

## Verification
The cases hardest to reach from the ports are the rollovers and the collisions between them and other commands. Waiting for a 32-bit counter to wrap is out of reach, so the stimulus preloads a counter to just below all ones through its own register and then lets events or cycles carry it over. The same preload puts an event overflow on exactly the edge that a flag-clearing write arrives, which checks that the flag stays set. The divide-by-64 mode is checked at the 63rd and 64th edges after a clear command, where the prescaler phase is known.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int REG_W     = 32;
  localparam int SEL_W     = 8;
  localparam int N_EVT_CTR = 2;
  localparam int N_SRC     = N_EVT_CTR + 1;

  // control word field positions (decoded by software)
  localparam int B_EN    = 0;
  localparam int B_EVCLR = 1;
  localparam int B_CYCLR = 2;
  localparam int B_DIV   = 3;
  localparam int B_IE    = 4;
  localparam int B_FLAG  = 8;
  localparam int B_SEL   = 12;
  localparam int B_TOP   = B_SEL + N_EVT_CTR * SEL_W;

  // source index inside flag and enable groups
  localparam int SRC_CYC = N_EVT_CTR;

  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_CYC  = 2'd1,
    IDX_EV0  = 2'd2,
    IDX_EV1  = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic [N_EVT_CTR-1:0][SEL_W-1:0] sel;
    logic [N_SRC-1:0]                flag;
    logic [N_SRC-1:0]                ie;
    logic                            div;
    logic                            en;
  } ctrl_t;

endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [N_SRC-1:0] ovf,
  output ctrl_t            q,
  output logic             ev_clr,
  output logic             cy_clr,
  output logic             irq,
  output logic [REG_W-1:0] view
);

  logic [N_SRC-1:0] w1c;
  logic             unused_bits;

  assign w1c    = wr ? wdata[B_FLAG +: N_SRC] : '0;
  assign ev_clr = wr & wdata[B_EVCLR];
  assign cy_clr = wr & wdata[B_CYCLR];
  assign irq    = |(q.flag & q.ie);
  assign unused_bits = ^{wdata[REG_W-1:B_TOP], wdata[B_FLAG-1], wdata[B_SEL-1:B_FLAG+N_SRC]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (wr) begin
        q.en  <= wdata[B_EN];
        q.div <= wdata[B_DIV];
        q.ie  <= wdata[B_IE +: N_SRC];
        for (int i = 0; i < N_EVT_CTR; i++)
          q.sel[i] <= wdata[B_SEL + i*SEL_W +: SEL_W];
      end
      // a new overflow wins over a clearing write
      q.flag <= (q.flag & ~w1c) | ovf;
    end
  end

  always_comb begin
    view = '0;
    view[B_EN]            = q.en;
    view[B_DIV]           = q.div;
    view[B_IE +: N_SRC]   = q.ie;
    view[B_FLAG +: N_SRC] = q.flag;
    for (int i = 0; i < N_EVT_CTR; i++)
      view[B_SEL + i*SEL_W +: SEL_W] = q.sel[i];
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag_chk
    // R6: overflow pulse always leaves its flag set
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[g] |=> q.flag[g]);
    // R7: flag stays until a 1 is written to it
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (q.flag[g] && !(wr && wdata[B_FLAG+g])) |=> q.flag[g]);
    // R7: clearing write without a fresh overflow drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[B_FLAG+g] && !ovf[g]) |=> !q.flag[g]);
  end

endmodule

// File: rtl/pmu_cycle_ctr.sv
module pmu_cycle_ctr #(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             div,
  input  logic             clr,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] presc;
  logic            tick;

  assign tick = en & (~div | (presc == PS_LAST));
  assign wrap = tick & ~wr & ~clr & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      presc <= '0;
    end else if (en && div) begin
      presc <= (presc == PS_LAST) ? '0 : presc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wr)    cnt <= wdata;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // R2: disabled counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr && !clr) |=> $stable(cnt));
  // R4: undivided mode steps by one
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !div && !wr && !clr) |=> cnt == $past(cnt) + CNT_W'(1));
  // R4: divided mode holds between prescaler terminal counts
  a_r4_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div && presc != PS_LAST && !wr && !clr) |=> $stable(cnt));
  // R3: clear zeroes counter and prescaler
  a_r3_cyc_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr) |=> (cnt == '0 && presc == '0));
  // R9: write loads value
  a_r9_cyc_wr: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt == $past(wdata));
  // R6: wrap lands at zero
  a_r6_cyc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);

endmodule

// File: rtl/pmu_event_ctr.sv
module pmu_event_ctr #(
  parameter int CNT_W = 32,
  parameter int EVT_W = 16,
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [EVT_W-1:0] evt,
  input  logic             clr,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam int IDX_W = (EVT_W > 2) ? $clog2(EVT_W) : 1;

  logic in_range;
  logic hit;

  assign in_range = (sel < SEL_W'(EVT_W));
  assign hit      = en & in_range & evt[sel[IDX_W-1:0]];
  assign wrap     = hit & ~wr & ~clr & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wr)   cnt <= wdata;
    else if (clr)  cnt <= '0;
    else if (hit)  cnt <= cnt + 1'b1;
  end

  // R5: out-of-range selector counts nothing
  a_r5_no_line: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_range && !wr && !clr) |=> $stable(cnt));
  // R2: disabled counter holds
  a_r2_ev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr && !clr) |=> $stable(cnt));
  // R3: clear zeroes the counter
  a_r3_ev_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr) |=> cnt == '0);
  // R9: write loads value
  a_r9_ev_wr: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt == $past(wdata));
  // R6: wrap lands at zero
  a_r6_ev_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int EVT_W    = 16,
  parameter int PRESCALE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0] evt_in,
  output logic             irq
);

  ctrl_t            ctrl;
  logic             ev_clr, cy_clr;
  logic [REG_W-1:0] ctrl_view;
  logic [N_SRC-1:0] ovf;
  logic [CNT_W-1:0] cyc_cnt;
  logic [N_EVT_CTR-1:0][CNT_W-1:0] ev_cnt;
  reg_idx_e         idx;

  assign idx = reg_idx_e'(reg_addr);

  pmu_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_we && idx == IDX_CTRL),
    .wdata  (reg_wdata),
    .ovf    (ovf),
    .q      (ctrl),
    .ev_clr (ev_clr),
    .cy_clr (cy_clr),
    .irq    (irq),
    .view   (ctrl_view)
  );

  pmu_cycle_ctr #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctrl.en),
    .div   (ctrl.div),
    .clr   (cy_clr),
    .wr    (reg_we && idx == IDX_CYC),
    .wdata (reg_wdata[CNT_W-1:0]),
    .cnt   (cyc_cnt),
    .wrap  (ovf[SRC_CYC])
  );

  for (genvar g = 0; g < N_EVT_CTR; g++) begin : g_evt
    pmu_event_ctr #(.CNT_W(CNT_W), .EVT_W(EVT_W), .SEL_W(SEL_W)) u_ev (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctrl.en),
      .sel   (ctrl.sel[g]),
      .evt   (evt_in),
      .clr   (ev_clr),
      .wr    (reg_we && reg_addr == 2'(32'(IDX_EV0) + g)),
      .wdata (reg_wdata[CNT_W-1:0]),
      .cnt   (ev_cnt[g]),
      .wrap  (ovf[g])
    );
  end

  always_comb begin
    unique case (idx)
      IDX_CTRL: reg_rdata = ctrl_view;
      IDX_CYC:  reg_rdata = REG_W'(cyc_cnt);
      IDX_EV0:  reg_rdata = REG_W'(ev_cnt[0]);
      default:  reg_rdata = REG_W'(ev_cnt[1]);
    endcase
  end

  // R8: interrupt only when some enabled flag is set
  a_r8_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_view[B_FLAG +: N_SRC] & ctrl_view[B_IE +: N_SRC]) != '0);
  // R1: command bits never read back
  a_r1_cmd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_CTRL) |-> (reg_rdata[B_EVCLR] == 1'b0 && reg_rdata[B_CYCLR] == 1'b0));

endmodule

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb;

  localparam int CLK_P = 10;
  localparam int NVEC  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] evt_in = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  perf_mon_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .irq       (irq)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [15:0] evt;
    logic [1:0]  chk;
    logic [31:0] exp;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  // ctrl 0x00503001: enable, event0 on line 3, event1 on line 5
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 2'd0, 32'h0050_3001, 16'h0000, 2'd0, 32'h0050_3001, 1'b0, 4'd1}, // R1
    '{1'b0, 2'd0, 32'h0,         16'h0008, 2'd1, 32'h0000_0001, 1'b0, 4'd4}, // R4
    '{1'b0, 2'd0, 32'h0,         16'h0028, 2'd2, 32'h0000_0002, 1'b0, 4'd5}, // R5
    '{1'b0, 2'd0, 32'h0,         16'h0020, 2'd3, 32'h0000_0002, 1'b0, 4'd5}, // R5
    '{1'b0, 2'd0, 32'h0,         16'h0000, 2'd1, 32'h0000_0004, 1'b0, 4'd4}, // R4
    '{1'b1, 2'd1, 32'hFFFF_FFFE, 16'h0000, 2'd1, 32'hFFFF_FFFE, 1'b0, 4'd9}, // R9
    '{1'b0, 2'd0, 32'h0,         16'h0000, 2'd1, 32'hFFFF_FFFF, 1'b0, 4'd4}, // R4
    '{1'b0, 2'd0, 32'h0,         16'h0000, 2'd1, 32'h0000_0000, 1'b0, 4'd6}, // R6
    '{1'b0, 2'd0, 32'h0,         16'h0000, 2'd0, 32'h0050_3401, 1'b0, 4'd6}, // R6
    '{1'b1, 2'd0, 32'h0050_3041, 16'h0000, 2'd0, 32'h0050_3441, 1'b1, 4'd8}, // R8
    '{1'b1, 2'd0, 32'h0050_3441, 16'h0000, 2'd0, 32'h0050_3041, 1'b0, 4'd7}, // R7
    '{1'b1, 2'd0, 32'h0050_3043, 16'h0008, 2'd2, 32'h0000_0000, 1'b0, 4'd3}, // R3
    '{1'b1, 2'd0, 32'h0050_3045, 16'h0000, 2'd1, 32'h0000_0000, 1'b0, 4'd3}, // R3
    '{1'b0, 2'd0, 32'h0,         16'h0000, 2'd0, 32'h0050_3041, 1'b0, 4'd1}, // R1
    '{1'b1, 2'd0, 32'h0050_3040, 16'hFFFF, 2'd1, 32'h0000_0002, 1'b0, 4'd2}, // R2
    '{1'b0, 2'd0, 32'h0,         16'hFFFF, 2'd2, 32'h0000_0001, 1'b0, 4'd2}  // R2
  };

  // one clock edge with the given inputs, then inputs return to idle
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d, input logic [15:0] e);
    reg_we = we; reg_addr = a; reg_wdata = d; evt_in = e;
    @(posedge clk);
    #1;
    reg_we = 1'b0; evt_in = '0;
  endtask

  task automatic idle(input int n, input logic [15:0] e);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'h0, e);
  endtask

  task automatic chk_reg(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d got %08h expected %08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq got %0b expected %0b", tag, irq, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) chk_reg(2'(a), 32'h0, "R1 reset");
    chk_irq(1'b0, "R1 reset irq");

    for (int i = 0; i < NVEC; i++) begin
      step(TBL[i].we, TBL[i].addr, TBL[i].wdata, TBL[i].evt);
      chk_reg(TBL[i].chk, TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].req, i));
      chk_irq(TBL[i].exp_irq, $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    // R5: selector 16 counts nothing, counter 1 on line 5 counts
    step(1'b1, 2'd0, 32'h0051_0003, 16'h0000);
    idle(5, 16'hFFFF);
    chk_reg(2'd2, 32'h0, "R5 selector out of range");
    chk_reg(2'd3, 32'd5, "R5 counter 1 line 5");

    // R4: divide by 64 after clear command
    step(1'b1, 2'd0, 32'h0051_000D, 16'h0000);
    chk_reg(2'd1, 32'h0, "R3 cycle clear");
    idle(63, 16'h0000);
    chk_reg(2'd1, 32'h0, "R4 divided at 63");
    idle(1, 16'h0000);
    chk_reg(2'd1, 32'd1, "R4 divided at 64");
    idle(128, 16'h0000);
    chk_reg(2'd1, 32'd3, "R4 divided at 192");

    // R9: write beats increment on event counter 1
    step(1'b1, 2'd3, 32'hFFFF_FFFE, 16'h0020);
    chk_reg(2'd3, 32'hFFFF_FFFE, "R9 write wins");
    step(1'b1, 2'd0, 32'h0051_0029, 16'h0020);
    chk_reg(2'd3, 32'hFFFF_FFFF, "R5 count toward wrap");
    idle(1, 16'h0020);
    chk_reg(2'd3, 32'h0, "R6 event wrap");
    chk_reg(2'd0, 32'h0051_0229, "R6 flag bit 9");
    chk_irq(1'b1, "R8 event irq");
    idle(1, 16'h0020);
    chk_reg(2'd3, 32'd1, "R6 keeps counting");

    // R7: plain clear of flag 9
    step(1'b1, 2'd0, 32'h0051_0229, 16'h0000);
    chk_reg(2'd0, 32'h0051_0029, "R7 clear flag");
    chk_irq(1'b0, "R7 irq drops");

    // R7: clear collides with a new overflow, flag stays
    step(1'b1, 2'd3, 32'hFFFF_FFFF, 16'h0000);
    step(1'b1, 2'd0, 32'h0051_0229, 16'h0020);
    chk_reg(2'd0, 32'h0051_0229, "R7 overflow beats clear");
    chk_irq(1'b1, "R8 irq after collision");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule